// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block is a two-wire serial bus target (I2C protocol) that holds six configuration bytes and one volatile fault status byte for a supply-management chip. A bus controller writes a single configuration byte per transaction, or reads one byte back, either from a chosen location or from wherever the internal pointer stands. The six configuration bytes drive the rest of the chip through one flat output bus. The fault byte is loaded by a neighbouring block and can be cleared over the bus.

The device address is a fixed four-bit type code, then three bus-address bits, then the read/write flag. Two of the bus-address bits come from strap pins. The third is a bit held in configuration byte 0. Writes are accepted only while an external unlock condition holds: the manual-reset input must be low and the power-on request input must be high. Reads are always allowed.

The bus lines are sampled by a fast system clock. Each line passes through a synchronizer and a short glitch filter. The target pulls SDA low through an output-enable and never drives it high.

Top module: `cfgi2c_top`

## Requirements
- R1: After reset the register contents are: byte 0 = 0xB4, byte 1 = 0x69, byte 2 = 0x41, byte 3 = 0x28, byte 4 = 0xF1, byte 5 = 0x21, fault byte (location 6) = 0x00. The read pointer is 0.
- R2: The address byte is sent MSB first as type code 1001, then bus-address bits [2:0], then the flag (1 = read). Bus-address bits [1:0] must equal `strap_a`, and bit [2] must equal bit 0 of configuration byte 0. A matching address is acknowledged by pulling SDA low during the ninth clock.
- R3: An address byte with a wrong type code or wrong bus-address bits is not acknowledged. The target then keeps SDA released and changes no state until the next START.
- R4: A write is: address (flag 0), register-location byte (only its low 4 bits are used), one data byte, STOP. Each of these bytes is acknowledged. The data byte lands in the addressed location 0..5.
- R5: A data byte changes a register only when `man_rst_n` is 0 and `pwr_on_n` is 1 at the moment the byte completes. Otherwise the byte is still acknowledged but the register keeps its value.
- R6: Only one data byte is taken per transaction. Any further byte before the next START is not acknowledged and has no effect.
- R7: A random read is: a write of the location byte, a repeated START, the address with flag 1, then one returned byte. It returns the addressed location whatever the level of `man_rst_n`.
- R8: The pointer advances by one, wrapping at 4 bits, after each byte read or written. A read with no preceding location byte returns the location after the last one accessed. Locations 7..15 read as 0x00 and ignore writes.
- R9: Read data leaves MSB first. The target changes its SDA drive only while the filtered SCL is low, and it releases SDA after the eighth bit so the controller can answer.
- R10: A one-cycle `flt_cap` pulse loads `flt_word` into the fault byte, and this takes priority over a bus write in the same cycle. An accepted write to location 6 clears the fault byte to 0x00, whatever the data, but only while `flt_present` is 0. While `flt_present` is 1 the fault byte is unchanged.
- R11: Each bus line is synchronized and filtered. A level that lasts fewer than `FILT_LEN` system clocks (3 by default) is ignored, so a one-cycle SCL pulse does not disturb a transfer.
- R12: `cfg_o` carries configuration byte k on bits [8k+7:8k], for k = 0..5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain drive) |
| strap_a | input | 2 | Pin-strapped bus-address bits [1:0] |
| man_rst_n | input | 1 | Manual reset, active low; must be 0 for writes |
| pwr_on_n | input | 1 | Power-on request, active low; must be 1 for writes |
| flt_cap | input | 1 | Load strobe for the fault byte |
| flt_word | input | 8 | Value loaded into the fault byte |
| flt_present | input | 1 | A fault is currently active; blocks clearing |
| cfg_o | output | 48 | Configuration bytes 0..5, byte k at bits [8k+7:8k] |

## Verification
A wrong pointer or wrong register state shows up at the ports within one transaction. A bad commit is visible on `cfg_o` about seven system clocks after the SCL fall that ends the data byte. A bad pointer shows up as the wrong byte on the very next current-address read, one bit per SCL period starting with the MSB. A wrong protocol state shows up as `sda_oe` asserted or released in the wrong ninth-clock slot, or as SDA changing while SCL is high. The bench therefore compares `cfg_o` and `sda_oe` with its model on every quiet clock and checks every acknowledge and every returned byte.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int NREG    = 7;
    localparam int FLT_IDX = NREG - 1;
    localparam int BYTE_W  = 8;
    localparam int PTR_W   = 4;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int CFG_W   = BYTE_W * (NREG - 1);
    localparam logic [3:0] DEV_TYPE = 4'b1001;

    typedef enum logic [3:0] {
        L_IDLE, L_ADDR, L_ADDR_ACK, L_REG, L_REG_ACK,
        L_WDAT, L_WDAT_ACK, L_RDAT, L_RDAT_ACK, L_SKIP
    } lnk_st_e;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hB4;
            1:       return 8'h69;
            2:       return 8'h41;
            3:       return 8'h28;
            4:       return 8'hF1;
            5:       return 8'h21;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [CFG_W-1:0] cfg_default_vec();
        logic [CFG_W-1:0] v;
        v = '0;
        for (int k = 0; k < NREG - 1; k++) v[k*BYTE_W +: BYTE_W] = reg_default(k);
        return v;
    endfunction

endpackage

// File: rtl/cfgi2c_filt.sv
module cfgi2c_filt #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic [CW-1:0]     cnt;
        logic              lvl;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[STAGES-2:0], raw};
        if (q.sync[STAGES-1] != q.lvl) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.lvl = q.sync[STAGES-1];
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.cnt  <= '0;
            q.lvl  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clean = q.lvl;
endmodule

// File: rtl/cfgi2c_link.sv
module cfgi2c_link
    import cfgi2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              a2,
    input  logic [1:0]        strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] byte_o,
    output logic              ptr_ld,
    output logic              wr_stb,
    output logic              rd_take
);
    typedef struct packed {
        lnk_st_e           st;
        logic              scl_p;
        logic              sda_p;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              rw;
        logic              oe;
        logic              ptr_ld;
        logic              wr_stb;
        logic              rd_take;
    } lnk_t;

    lnk_t q, d;
    logic rise, fall, start, stop, hit, done8;

    always_comb begin
        rise  = scl & ~q.scl_p;
        fall  = ~scl & q.scl_p;
        start = scl & q.scl_p & q.sda_p & ~sda;
        stop  = scl & q.scl_p & ~q.sda_p & sda;
        hit   = (q.sh[7:4] == DEV_TYPE) && (q.sh[3] == a2) && (q.sh[2:1] == strap);
        done8 = (q.cnt == CNT_W'(BYTE_W));

        d         = q;
        d.scl_p   = scl;
        d.sda_p   = sda;
        d.ptr_ld  = 1'b0;
        d.wr_stb  = 1'b0;
        d.rd_take = 1'b0;

        if (start) begin
            d.st  = L_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop) begin
            d.st  = L_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                L_ADDR, L_REG, L_WDAT: begin
                    if (rise && !done8) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall && done8) begin
                        d.cnt = '0;
                        if (q.st == L_ADDR) begin
                            if (hit) begin
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                                d.st = L_ADDR_ACK;
                            end else begin
                                d.st = L_SKIP;
                            end
                        end else if (q.st == L_REG) begin
                            d.oe     = 1'b1;
                            d.ptr_ld = 1'b1;
                            d.st     = L_REG_ACK;
                        end else begin
                            d.oe     = 1'b1;
                            d.wr_stb = 1'b1;
                            d.st     = L_WDAT_ACK;
                        end
                    end
                end
                L_ADDR_ACK: begin
                    if (fall) begin
                        if (q.rw) begin
                            d.st      = L_RDAT;
                            d.sh      = rd_data;
                            d.oe      = ~rd_data[BYTE_W-1];
                            d.rd_take = 1'b1;
                            d.cnt     = '0;
                        end else begin
                            d.oe = 1'b0;
                            d.st = L_REG;
                        end
                    end
                end
                L_REG_ACK: begin
                    if (fall) begin
                        d.oe = 1'b0;
                        d.st = L_WDAT;
                    end
                end
                L_WDAT_ACK: begin
                    if (fall) begin
                        d.oe = 1'b0;
                        d.st = L_SKIP;
                    end
                end
                L_RDAT: begin
                    if (fall) begin
                        if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                            d.oe = 1'b0;
                            d.st = L_RDAT_ACK;
                        end else begin
                            d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            d.oe  = ~q.sh[BYTE_W-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                L_RDAT_ACK: begin
                    if (fall) d.st = L_SKIP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= L_IDLE;
            q.scl_p   <= 1'b1;
            q.sda_p   <= 1'b1;
            q.cnt     <= '0;
            q.sh      <= '0;
            q.rw      <= 1'b0;
            q.oe      <= 1'b0;
            q.ptr_ld  <= 1'b0;
            q.wr_stb  <= 1'b0;
            q.rd_take <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign byte_o  = q.sh;
    assign ptr_ld  = q.ptr_ld;
    assign wr_stb  = q.wr_stb;
    assign rd_take = q.rd_take;
endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs
    import cfgi2c_pkg::*;
#(
    parameter int A2_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_ld,
    input  logic              wr_stb,
    input  logic              rd_take,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              wr_open,
    input  logic              flt_cap,
    input  logic [BYTE_W-1:0] flt_word,
    input  logic              flt_present,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              a2
);
    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] r;
        logic [PTR_W-1:0]            ptr;
    } reg_t;

    reg_t q, d;

    always_comb begin
        d = q;
        if (ptr_ld)  d.ptr = byte_i[PTR_W-1:0];
        if (rd_take) d.ptr = q.ptr + 1'b1;
        if (wr_stb) begin
            d.ptr = q.ptr + 1'b1;
            if (wr_open) begin
                for (int i = 0; i < FLT_IDX; i++)
                    if (q.ptr == PTR_W'(i)) d.r[i] = byte_i;
                if (q.ptr == PTR_W'(FLT_IDX) && !flt_present) d.r[FLT_IDX] = '0;
            end
        end
        if (flt_cap) d.r[FLT_IDX] = flt_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) q.r[i] <= reg_default(i);
            q.ptr <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (q.ptr == PTR_W'(i)) rd_data = q.r[i];
    end

    for (genvar k = 0; k < NREG - 1; k++) begin : g_cfg
        assign cfg_o[k*BYTE_W +: BYTE_W] = q.r[k];
    end

    assign a2 = q.r[0][A2_BIT];
endmodule

// File: rtl/cfgi2c_top.sv
module cfgi2c_top
    import cfgi2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int A2_BIT      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        strap_a,
    input  logic              man_rst_n,
    input  logic              pwr_on_n,
    input  logic              flt_cap,
    input  logic [BYTE_W-1:0] flt_word,
    input  logic              flt_present,
    output logic [CFG_W-1:0]  cfg_o
);
    logic              scl_f, sda_f;
    logic              a2;
    logic [BYTE_W-1:0] rd_data, byte_x;
    logic              ptr_ld, wr_stb, rd_take;
    logic              wr_open;

    assign wr_open = ~man_rst_n & pwr_on_n;

    cfgi2c_filt #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_f)
    );

    cfgi2c_filt #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_f)
    );

    cfgi2c_link u_link (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .a2(a2), .strap(strap_a), .rd_data(rd_data),
        .sda_oe(sda_oe), .byte_o(byte_x),
        .ptr_ld(ptr_ld), .wr_stb(wr_stb), .rd_take(rd_take)
    );

    cfgi2c_regs #(.A2_BIT(A2_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .wr_stb(wr_stb),
        .rd_take(rd_take), .byte_i(byte_x), .wr_open(wr_open),
        .flt_cap(flt_cap), .flt_word(flt_word), .flt_present(flt_present),
        .rd_data(rd_data), .cfg_o(cfg_o), .a2(a2)
    );
endmodule

// File: rtl/cfgi2c_chk.sv
module cfgi2c_chk
    import cfgi2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             sda_f,
    input logic             sda_oe,
    input logic             man_rst_n,
    input logic             pwr_on_n,
    input logic             wr_stb,
    input logic [CFG_W-1:0] cfg_o
);
    logic scl_p, sda_p, wr_seen;
    logic start_seen;

    assign start_seen = scl_f & scl_p & sda_p & ~sda_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p   <= 1'b1;
            sda_p   <= 1'b1;
            wr_seen <= 1'b0;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
            if (start_seen)  wr_seen <= 1'b0;
            else if (wr_stb) wr_seen <= 1'b1;
        end
    end

    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (cfg_o == cfg_default_vec()));

    // R5
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(!man_rst_n && pwr_on_n));

    // R9
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R6
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !wr_seen);
endmodule

bind cfgi2c_top cfgi2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .sda_oe(sda_oe), .man_rst_n(man_rst_n), .pwr_on_n(pwr_on_n),
    .wr_stb(wr_stb), .cfg_o(cfg_o)
);

// File: tb/tb_cfgi2c_top.sv
`timescale 1ns/1ps
module tb_cfgi2c_top;
    localparam int Q = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        sda_oe, sda_line;
    logic [1:0]  strap_a = 2'b10;
    logic        man_rst_n = 1'b0, pwr_on_n = 1'b1;
    logic        flt_cap = 1'b0, flt_present = 1'b0;
    logic [7:0]  flt_word = 8'h00;
    logic [47:0] cfg_o;

    always #2.5 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    cfgi2c_top dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_a(strap_a), .man_rst_n(man_rst_n), .pwr_on_n(pwr_on_n),
        .flt_cap(flt_cap), .flt_word(flt_word), .flt_present(flt_present), .cfg_o(cfg_o)
    );

    // reference model
    logic [7:0] exp_reg [16];
    int         exp_ptr;
    logic       exp_oe = 1'b0;
    int         since_edge = 0;
    bit         run_cmp = 0, done = 0;
    bit         pend_on = 0;
    int         pend_idx;
    logic [7:0] pend_val;
    int         n_chk = 0, n_err = 0;

    function automatic logic [47:0] exp_cfg();
        logic [47:0] v;
        for (int k = 0; k < 6; k++) v[k*8 +: 8] = exp_reg[k];
        return v;
    endfunction

    function automatic logic [7:0] dev(input bit rd);
        return {4'b1001, exp_reg[0][0], strap_a, rd};
    endfunction

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    always @(posedge clk) since_edge <= since_edge + 1;

    always @(negedge clk) begin
        if (run_cmp && !done && since_edge >= 12) begin
            chk_eq("R12 cfg_o per-clock", cfg_o, exp_cfg());
            chk_eq("R9 sda_oe per-clock", sda_oe, exp_oe);
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic set_scl(input logic v);
        @(negedge clk); m_scl = v; since_edge = 0;
    endtask
    task automatic set_sda(input logic v);
        @(negedge clk); m_sda = v; since_edge = 0;
    endtask

    task automatic apply_pending();
        if (pend_on) begin
            if (!man_rst_n && pwr_on_n) begin
                if (pend_idx < 6) exp_reg[pend_idx] = pend_val;
                else if (pend_idx == 6 && !flt_present) exp_reg[6] = 8'h00;
            end
            pend_on = 0;
        end
    endtask

    task automatic i2c_start();
        set_sda(1'b1); wq(Q); set_scl(1'b1); wq(Q);
        set_sda(1'b0); wq(Q); set_scl(1'b0); wq(Q);
    endtask

    task automatic i2c_stop();
        set_sda(1'b0); wq(Q); set_scl(1'b1); wq(Q); set_sda(1'b1); wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit will_ack, input bit commit,
                             input bit after_oe, input bit glitch, output bit got_ack);
        for (int i = 7; i >= 0; i--) begin
            set_sda(b[i]); wq(Q);
            if (glitch && i == 3) begin
                @(negedge clk); m_scl = 1'b1; @(negedge clk); m_scl = 1'b0; since_edge = 0;
            end
            set_scl(1'b1); wq(2*Q); set_scl(1'b0);
            if (i == 0) begin
                if (commit) apply_pending();
                exp_oe = will_ack;
            end
            wq(Q);
        end
        set_sda(1'b1); wq(Q); set_scl(1'b1); wq(Q);
        got_ack = ~sda_line;
        wq(Q); set_scl(1'b0); exp_oe = after_oe; wq(Q);
    endtask

    task automatic recv_byte(input logic [7:0] expd, input bit mack, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            wq(Q); set_scl(1'b1); wq(Q);
            got[i] = sda_line;
            wq(Q); set_scl(1'b0);
            exp_oe = (i > 0) ? ~expd[i-1] : 1'b0;
        end
        wq(Q); set_sda(mack ? 1'b0 : 1'b1); wq(Q); set_scl(1'b1); wq(2*Q);
        set_scl(1'b0); wq(Q);
    endtask

    task automatic write_reg(input string tag, input int idx, input logic [7:0] val, input bit glitch);
        bit a;
        i2c_start();
        send_byte(dev(0), 1, 0, 0, 0, a);        chk_eq({tag, " addr ack"}, a, 1);
        send_byte(8'(idx), 1, 0, 0, 0, a);       chk_eq({tag, " reg ack"}, a, 1);
        pend_on = 1; pend_idx = idx; pend_val = val;
        send_byte(val, 1, 1, 0, glitch, a);      chk_eq({tag, " data ack"}, a, 1);
        exp_ptr = (idx + 1) % 16;
        i2c_stop();
    endtask

    task automatic rand_read(input string tag, input int idx, input logic [7:0] expv);
        bit a; logic [7:0] g;
        i2c_start();
        send_byte(dev(0), 1, 0, 0, 0, a);        chk_eq({tag, " addr ack"}, a, 1);
        send_byte(8'(idx), 1, 0, 0, 0, a);       chk_eq({tag, " reg ack"}, a, 1);
        i2c_start();
        send_byte(dev(1), 1, 0, ~expv[7], 0, a); chk_eq({tag, " raddr ack"}, a, 1);
        recv_byte(expv, 0, g);                   chk_eq({tag, " data"}, g, expv);
        exp_ptr = (idx + 1) % 16;
        i2c_stop();
    endtask

    task automatic cur_read(input string tag);
        bit a; logic [7:0] g, e;
        e = exp_reg[exp_ptr];
        i2c_start();
        send_byte(dev(1), 1, 0, ~e[7], 0, a);    chk_eq({tag, " addr ack"}, a, 1);
        recv_byte(e, 0, g);                      chk_eq({tag, " data"}, g, e);
        exp_ptr = (exp_ptr + 1) % 16;
        i2c_stop();
    endtask

    task automatic fault_capture(input logic [7:0] w);
        @(negedge clk); flt_word = w; flt_cap = 1'b1; exp_reg[6] = w; since_edge = 0;
        @(negedge clk); flt_cap = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (all requirements) act=timeout exp=finished");
            finish_run();
        end
    end

    initial begin
        bit a;
        for (int i = 0; i < 16; i++) exp_reg[i] = 8'h00;
        exp_reg[0] = 8'hB4; exp_reg[1] = 8'h69; exp_reg[2] = 8'h41;
        exp_reg[3] = 8'h28; exp_reg[4] = 8'hF1; exp_reg[5] = 8'h21;
        exp_ptr = 0;
        wq(5);
        @(negedge clk); rst_n = 1'b1;
        wq(20);
        run_cmp = 1;
        // R1: reset values and pointer
        chk_eq("R1 reset cfg_o", cfg_o, 48'h21F1_2841_69B4);
        chk_eq("R1 reset sda_oe", sda_oe, 0);
        cur_read("R1 pointer at 0 after reset");
        rand_read("R1 fault byte reset", 6, 8'h00);

        // R4: unlocked write then read back
        write_reg("R4 write", 2, 8'h5A, 0);
        rand_read("R4 readback", 2, 8'h5A);
        // R8: current address reads continue from pointer
        cur_read("R8 current read loc3");
        cur_read("R8 current read loc4");

        // R5: locked writes ignored, R7 reads not gated
        man_rst_n = 1'b1;
        write_reg("R5 locked by manual reset", 1, 8'h33, 0);
        rand_read("R7 read with manual reset high", 1, 8'h69);
        man_rst_n = 1'b0; pwr_on_n = 1'b0;
        write_reg("R5 locked by power request", 1, 8'h33, 0);
        rand_read("R5 readback", 1, 8'h69);
        pwr_on_n = 1'b1;

        // R6: second data byte refused
        i2c_start();
        send_byte(dev(0), 1, 0, 0, 0, a);  chk_eq("R6 addr ack", a, 1);
        send_byte(8'd3, 1, 0, 0, 0, a);    chk_eq("R6 reg ack", a, 1);
        pend_on = 1; pend_idx = 3; pend_val = 8'hAA;
        send_byte(8'hAA, 1, 1, 0, 0, a);   chk_eq("R6 first data ack", a, 1);
        send_byte(8'hBB, 0, 0, 0, 0, a);   chk_eq("R6 second data nack", a, 0);
        exp_ptr = 4;
        i2c_stop();
        rand_read("R6 loc3", 3, 8'hAA);
        rand_read("R6 loc4 untouched", 4, 8'hF1);

        // R2: bus-address bit 2 follows config byte 0 bit 0; straps
        write_reg("R2 set a2", 0, 8'hB5, 0);
        i2c_start();
        send_byte({4'b1001, 1'b0, strap_a, 1'b1}, 0, 0, 0, 0, a);
        chk_eq("R2 old a2 nack", a, 0);
        i2c_stop();
        rand_read("R2 new a2 read", 0, 8'hB5);
        strap_a = 2'b01;
        i2c_start();
        send_byte({4'b1001, 1'b1, 2'b10, 1'b0}, 0, 0, 0, 0, a);
        chk_eq("R2 old strap nack", a, 0);
        i2c_stop();
        rand_read("R2 new strap read", 5, 8'h21);

        // R3: wrong type code, following bytes ignored
        i2c_start();
        send_byte({4'b1010, 1'b1, strap_a, 1'b0}, 0, 0, 0, 0, a); chk_eq("R3 type nack", a, 0);
        send_byte(8'h02, 0, 0, 0, 0, a);                          chk_eq("R3 reg byte nack", a, 0);
        send_byte(8'h77, 0, 0, 0, 0, a);                          chk_eq("R3 data nack", a, 0);
        i2c_stop();
        rand_read("R3 loc2 untouched", 2, 8'h5A);

        // R8: empty locations and wrap
        rand_read("R8 loc9 empty", 9, 8'h00);
        write_reg("R8 write loc9", 9, 8'hC3, 0);
        rand_read("R8 loc9 still empty", 9, 8'h00);
        rand_read("R8 loc15", 15, 8'h00);
        cur_read("R8 wrap to loc0");

        // R10: fault byte capture and clear
        flt_present = 1'b1;
        fault_capture(8'h8C);
        wq(20);
        rand_read("R10 captured", 6, 8'h8C);
        write_reg("R10 clear blocked", 6, 8'h55, 0);
        rand_read("R10 still set", 6, 8'h8C);
        flt_present = 1'b0;
        write_reg("R10 clear", 6, 8'h55, 0);
        rand_read("R10 cleared", 6, 8'h00);

        // R11: one-cycle SCL pulse is filtered
        write_reg("R11 glitch write", 5, 8'h96, 1);
        rand_read("R11 readback", 5, 8'h96);
        wq(40);
        chk_eq("R12 final cfg_o", cfg_o, exp_cfg());
        finish_run();
    end
endmodule